// File: doc/BRIEF.md
# Single-Wire Bit Memory Host Sequencer

This block is the host side of a serial bit memory that shares one open-drain wire for command, address and data. One start pulse runs a full transaction, built from time slots that the block shapes from a clock-cycles-per-microsecond parameter. A transaction begins with 264 write-zero slots that lock the memory's internal pointer at its top count. A command byte follows, and its leading one clears that lock. The transaction ends with 256 data slots that move one bit each.

The user chooses write or read with `wr_i` and supplies a 256-bit write vector. A read returns a 256-bit vector that is valid in the cycle `done_o` pulses. On the pad side, the block drives a pull-low enable and takes in the raw wire level, which it synchronises itself. The block also synchronises the release of its asynchronous active-low reset.

Top module: `swm_host_seq`

## Requirements
- R1: While reset is asserted, and whenever the block is idle, `pull_low_o`, `busy_o` and `done_o` are all low.
- R2: The first 264 slots of every transaction are write-zero slots.
- R3: Slots 264 to 271 carry the command byte, least significant bit first. The byte value is 0xF9 for a write (bit 0 is one, bits 2:1 are the select field 00, bits 7:3 are all ones). The byte value is 0x01 for a read (bits 7:3 are all zeros).
- R4: A write-one slot and a read slot each pull the wire low for 5 µs. A write-zero slot pulls it low for 65 µs.
- R5: Slot starts are 70 µs apart. This leaves at least 5 µs of released wire between slots.
- R6: In a write, data slot k (k = 0 to 255, slots 272 to 527) sends bit k of `wdata_i`, as it was captured at start, least significant bit first.
- R7: In a read, data slot k samples the wire 12 µs after its falling edge into bit k of `rdata_o`. The full vector is valid when `done_o` pulses.
- R8: `busy_o` rises in the cycle after an accepted start and stays high until the last slot ends. `done_o` then pulses for exactly one cycle, in the same cycle that `busy_o` falls.
- R9: A start request while `busy_o` is high is ignored. It changes neither the mode, the data, nor the number of slots, and no transaction is queued.
- R10: A transaction has exactly 528 slots, after which the wire stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken when not busy |
| wr_i | input | 1 | 1 selects a write, 0 a read; captured with start |
| wdata_i | input | 256 | Bits to write, captured with start |
| rdata_o | output | 256 | Bits read, bit 0 first on the wire |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| pull_low_o | output | 1 | Pad enable that pulls the wire low |
| line_i | input | 1 | Raw wire level from the pad |

## Verification
A slot counter that drifts shows at once on `pull_low_o`, within a single slot. The pulse widths stop being 5 or 65 µs, or slot starts stop being 70 µs apart. An error in the slot index or the mode bit shows by slot 271: either a preamble bit is non-zero or the command byte is wrong. Errors in the data shift registers show only when `done_o` pulses. They appear as written bits that differ from the captured vector, or read bits that differ from the model memory. The total slot count is also seen at `done_o`.

// File: rtl/swm_pkg.sv
package swm_pkg;

  typedef enum logic [1:0] {
    SLOT_W0 = 2'd0,
    SLOT_W1 = 2'd1,
    SLOT_RD = 2'd2
  } slot_kind_e;

  // Command byte, sent bit 0 first: start bit, select 00, then mode bits.
  function automatic logic [7:0] cmd_byte(input logic wr);
    return wr ? 8'hF9 : 8'h01;
  endfunction

endpackage

// File: rtl/swm_sync.sv
module swm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic line_i,
  output logic rst_n_o,
  output logic line_o
);

  logic [STAGES-1:0] rst_q;
  logic [STAGES-1:0] line_q;

  // Reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_q <= '0;
    else         rst_q <= {rst_q[STAGES-2:0], 1'b1};
  end

  // The idle wire is high, so the chain resets to ones.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) line_q <= '1;
    else         line_q <= {line_q[STAGES-2:0], line_i};
  end

  assign rst_n_o = rst_q[STAGES-1];
  assign line_o  = line_q[STAGES-1];

endmodule

// File: rtl/swm_slot.sv
module swm_slot
  import swm_pkg::*;
#(
  parameter int unsigned CLK_PER_US = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_i,
  input  slot_kind_e kind_i,
  output logic       pull_low_o,
  output logic       sample_o,
  output logic       end_o
);

  localparam int unsigned SLOT_CYC  = 70 * CLK_PER_US;
  localparam int unsigned LOW_SHORT = 5 * CLK_PER_US;
  localparam int unsigned LOW_LONG  = 65 * CLK_PER_US;
  localparam int unsigned SAMPLE_AT = 12 * CLK_PER_US;
  localparam int unsigned CW        = $clog2(SLOT_CYC);
  localparam logic [CW-1:0] C_LAST  = CW'(SLOT_CYC - 1);
  localparam logic [CW-1:0] C_SHORT = CW'(LOW_SHORT);
  localparam logic [CW-1:0] C_LONG  = CW'(LOW_LONG);
  localparam logic [CW-1:0] C_SAMP  = CW'(SAMPLE_AT);

  logic          act_q, act_d;
  logic [CW-1:0] cnt_q, cnt_d;
  slot_kind_e    kind_q, kind_d;
  logic          pull_q, pull_d;
  logic [CW-1:0] low_len;

  assign end_o      = act_q && (cnt_q == C_LAST);
  assign sample_o   = act_q && (kind_q == SLOT_RD) && (cnt_q == C_SAMP);
  assign pull_low_o = pull_q;

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    kind_d = kind_q;
    if (go_i) begin
      act_d  = 1'b1;
      cnt_d  = '0;
      kind_d = kind_i;
    end else if (end_o) begin
      act_d = 1'b0;
      cnt_d = '0;
    end else if (act_q) begin
      cnt_d = cnt_q + 1'b1;
    end
    low_len = (kind_d == SLOT_W0) ? C_LONG : C_SHORT;
    pull_d  = act_d && (cnt_d < low_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      kind_q <= SLOT_W0;
      pull_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
      pull_q <= pull_d;
    end
  end

  // R5: the wire is released before the slot closes
  a_r5_released_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |-> !pull_low_o);

  // R7: the host has let go of the wire when read data is sampled
  a_r7_sample_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> !pull_low_o);

  // R4: a short slot never holds the wire past its low time
  a_r4_short_low: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && kind_q != SLOT_W0 && cnt_q >= C_SHORT) |-> !pull_low_o);

endmodule

// File: rtl/swm_host_seq.sv
module swm_host_seq
  import swm_pkg::*;
#(
  parameter int unsigned CLK_PER_US = 50,
  parameter int unsigned DATA_BITS  = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic                 wr_i,
  input  logic [DATA_BITS-1:0] wdata_i,
  output logic [DATA_BITS-1:0] rdata_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 pull_low_o,
  input  logic                 line_i
);

  localparam int unsigned CMD_BITS   = 8;
  localparam int unsigned SYNC_SLOTS = DATA_BITS + CMD_BITS;
  localparam int unsigned DATA_START = SYNC_SLOTS + CMD_BITS;
  localparam int unsigned TOTAL      = DATA_START + DATA_BITS;
  localparam int unsigned IW         = $clog2(TOTAL);
  localparam logic [IW-1:0] I_LAST   = IW'(TOTAL - 1);
  localparam logic [IW-1:0] I_SYNC   = IW'(SYNC_SLOTS);
  localparam logic [IW-1:0] I_DATA   = IW'(DATA_START);
  localparam logic [2:0]    CMD_OFS  = 3'(SYNC_SLOTS % CMD_BITS);

  logic                 rst_s, line_s;
  logic                 busy_q, busy_d;
  logic                 done_q, done_d;
  logic                 wr_q, wr_d;
  logic [IW-1:0]        idx_q, idx_d;
  logic [DATA_BITS-1:0] wsh_q, wsh_d;
  logic [DATA_BITS-1:0] rsh_q, rsh_d;
  logic                 go;
  slot_kind_e           kind;
  logic                 slot_end, slot_sample;
  logic [7:0]           cmd_v;
  logic [2:0]           cmd_sel;

  swm_sync #(.STAGES(2)) u_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .line_i (line_i),
    .rst_n_o(rst_s),
    .line_o (line_s)
  );

  swm_slot #(.CLK_PER_US(CLK_PER_US)) u_slot (
    .clk       (clk),
    .rst_n     (rst_s),
    .go_i      (go),
    .kind_i    (kind),
    .pull_low_o(pull_low_o),
    .sample_o  (slot_sample),
    .end_o     (slot_end)
  );

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    wr_d   = wr_q;
    idx_d  = idx_q;
    wsh_d  = wsh_q;
    rsh_d  = rsh_q;
    go     = 1'b0;
    if (!busy_q && start_i) begin
      busy_d = 1'b1;
      wr_d   = wr_i;
      idx_d  = '0;
      wsh_d  = wdata_i;
      go     = 1'b1;
    end else if (busy_q && slot_end) begin
      if (idx_q == I_LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
        go    = 1'b1;
        if (idx_q >= I_DATA) wsh_d = wsh_q >> 1;
      end
    end
    if (slot_sample) rsh_d = {line_s, rsh_q[DATA_BITS-1:1]};

    // kind of the slot that starts with go
    cmd_v   = cmd_byte(wr_d);
    cmd_sel = idx_d[2:0] - CMD_OFS;
    if (idx_d < I_SYNC)      kind = SLOT_W0;
    else if (idx_d < I_DATA) kind = cmd_v[cmd_sel] ? SLOT_W1 : SLOT_W0;
    else if (wr_d)           kind = wsh_d[0] ? SLOT_W1 : SLOT_W0;
    else                     kind = SLOT_RD;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      wr_q   <= 1'b0;
      idx_q  <= '0;
      wsh_q  <= '0;
      rsh_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      wr_q   <= wr_d;
      idx_q  <= idx_d;
      wsh_q  <= wsh_d;
      rsh_q  <= rsh_d;
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign rdata_o = rsh_q;

  // R8: done lasts one cycle
  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_s)
    done_q |=> !done_q);

  // R8: done marks the fall of busy
  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_s)
    done_q |-> (!busy_q && $past(busy_q)));

  // R9: the mode stays fixed for the whole transaction
  a_r9_mode_held: assert property (@(posedge clk) disable iff (!rst_s)
    (busy_q && $past(busy_q)) |-> $stable(wr_q));

  // R1: no pull on the wire while idle
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_s)
    !busy_q |-> !pull_low_o);

  // R10: the slot index stays within one transaction
  a_r10_idx_range: assert property (@(posedge clk) disable iff (!rst_s)
    idx_q <= I_LAST);

endmodule

// File: tb/swm_host_seq_bench.sv
module swm_host_seq_bench;

  localparam int SLOT   = 70;
  localparam int TOTAL  = 528;
  localparam logic [255:0] PA = {64'hF00D_1234_89AB_CDEF, 64'h0123_4567_0000_FFFF,
                                 64'h8000_0000_0000_0001, 64'h5A5A_C3C3_9696_0F0F};
  localparam logic [255:0] PB = {64'h0000_0000_FFFF_FFFF, 64'hDEAD_BEEF_7777_1111,
                                 64'h3C96_A5E1_0246_8ACE, 64'h1357_9BDF_FEDC_BA98};
  // {wr, data}: write A, read back, write B
  localparam logic [256:0] VECS [3] = '{ {1'b1, PA}, {1'b0, 256'd0}, {1'b1, PB} };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         wr_i = 1'b0;
  logic [255:0] wdata_i = '0;
  logic [255:0] rdata_o;
  logic         busy_o, done_o, pull_low_o;
  logic         line_i;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // slave model state
  int           cyc = 0;
  int           n_slots = 0, pre_err = 0, wid_err = 0, per_err = 0;
  int           w = 0, last_start = 0, cur_idx = 0, slave_cnt = 0;
  logic         hp_prev = 1'b0;
  logic         m_wr = 1'b0;
  logic         bitv;
  logic [7:0]   cmd_m = '0;
  logic [255:0] cap = '0;
  logic [255:0] mem = '0;

  always #2 clk = ~clk;

  assign line_i = !(pull_low_o || (slave_cnt != 0));

  swm_host_seq #(.CLK_PER_US(1), .DATA_BITS(256)) u_swm_host_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .wr_i      (wr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .pull_low_o(pull_low_o),
    .line_i    (line_i)
  );

  // slave: classify each host pulse and drive read bits
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (slave_cnt > 0) slave_cnt = slave_cnt - 1;
    if (pull_low_o && !hp_prev) begin
      if (n_slots > 0 && (cyc - last_start) != SLOT) per_err = per_err + 1;
      last_start = cyc;
      cur_idx = n_slots;
      n_slots = n_slots + 1;
      w = 1;
      if (cur_idx >= 272 && !m_wr && !mem[cur_idx-272]) slave_cnt = 15;
    end else if (pull_low_o) begin
      w = w + 1;
    end else if (hp_prev) begin
      if (w == 5) bitv = 1'b1;
      else if (w == 65) bitv = 1'b0;
      else begin wid_err = wid_err + 1; bitv = 1'b0; end
      if (cur_idx < 264) begin
        if (bitv) pre_err = pre_err + 1;
      end else if (cur_idx < 272) begin
        cmd_m[cur_idx-264] = bitv;
        if (cur_idx == 271) m_wr = &cmd_m[7:3];
      end else if (m_wr) begin
        cap[cur_idx-272] = bitv;
      end
    end
    hp_prev = pull_low_o;
  end

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_model();
    n_slots = 0; pre_err = 0; wid_err = 0; per_err = 0;
    cmd_m = '0; m_wr = 1'b0; cap = '0;
  endtask

  task automatic run_txn(input logic wr, input logic [255:0] d, input bit inject);
    clr_model();
    @(negedge clk);
    wr_i = wr; wdata_i = d; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R8 busy after start", busy_o, 1);
    if (inject) begin
      repeat (3000) @(negedge clk);
      wr_i = !wr; wdata_i = ~d; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1'b1, "R9 busy kept through ignored start", busy_o, 1);
    end
    while (done_o !== 1'b1) @(negedge clk);
    chk(busy_o == 1'b0, "R8 busy low with done", busy_o, 0);
    if (!wr) chk(rdata_o == mem, "R7 read vector at done", rdata_o, mem);
    @(negedge clk);
    chk(done_o == 1'b0, "R8 done single cycle", done_o, 0);
    repeat (100) @(negedge clk);
    chk(n_slots == TOTAL, "R10 slot count", n_slots, TOTAL);
    chk(pull_low_o == 1'b0 && busy_o == 1'b0, "R10 idle after transaction", pull_low_o, 0);
    chk(pre_err == 0, "R2 preamble all zero", pre_err, 0);
    chk(cmd_m == (wr ? 8'hF9 : 8'h01), "R3 command byte", cmd_m, wr ? 8'hF9 : 8'h01);
    chk(wid_err == 0, "R4 low pulse widths", wid_err, 0);
    chk(per_err == 0, "R5 slot spacing", per_err, 0);
    if (wr) begin
      chk(cap == d, "R6 written bits", cap, d);
      mem = cap;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(pull_low_o == 1'b0, "R1 reset pull", pull_low_o, 0);
    chk(busy_o == 1'b0, "R1 reset busy", busy_o, 0);
    chk(done_o == 1'b0, "R1 reset done", done_o, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    for (int i = 0; i < 3; i++) run_txn(VECS[i][256], VECS[i][255:0], 1'b0);

    // reset in the middle of a write preamble
    clr_model();
    @(negedge clk);
    wr_i = 1'b1; wdata_i = 256'd0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (400) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(pull_low_o == 1'b0, "R1 pull cleared by reset", pull_low_o, 0);
    chk(busy_o == 1'b0, "R1 busy cleared by reset", busy_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (200) @(negedge clk);
    chk(busy_o == 1'b0 && pull_low_o == 1'b0, "R1 idle after reset", busy_o, 0);

    // read of B with an ignored start in the middle
    run_txn(1'b0, 256'd0, 1'b1);
    chk(rdata_o == PB, "R9 read unaffected by stray start", rdata_o, PB);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule